// File: doc/BRIEF.md
# Shared Fault Line Propagation Controller

This block coordinates fault shutdown and recovery across a group of regulator channels that share one active-low, open-drain fault line. A channel with propagation enabled pulls the line down when its internal fault flag is seen. Every channel set to respond to the line shuts down while the line reads low, whatever pulled it low. The block drives only a pull-down enable. It reads back the resolved line level, which is the wired-AND of every driver on the line, including drivers outside the block.

Each channel holds the line in one of two recovery styles. In the latched style, the pull-down stays on until a release event arrives. A release event is a group clear command, a write of one to the channel's status bit, or a full off-then-on cycle of the channel enable. In the timed style, the pull-down stays on for a programmable number of cycles. It is released only if the fault has gone; otherwise the wait starts again. When a timed release lets the line rise, every enabled channel receives a one-cycle soft-start request in the same cycle. A group-wide mode turns the line into a power-good output instead.

Top module: `fault_line_ctrl`

## Requirements
- R1: When a channel's propagation enable and fault flag are both 1 at a clock edge, `line_pd_o` is 1 from that edge onward. A fault on a channel whose propagation enable is 0 never sets `line_pd_o`.
- R2: `ch_shutdown_o[i]` is 1 in the same cycle as `ch_en_i[i]` = 0, or as `line_i` = 0 while `cfg_resp_en_i[i]` = 1, with no filtering and no clock delay. With `cfg_resp_en_i[i]` = 0 the line level has no effect on that channel.
- R3: A channel in latched style (`cfg_retry_mode_i[i]` = 0) keeps the line pulled down for any length of time after its fault clears, until a release event from R4 or R5 occurs.
- R4: A one-cycle `clear_all_i` pulse, or a pulse on that channel's own `stat_w1c_i[i]` bit, releases that channel's hold at that edge. A `stat_w1c_i` pulse on another channel leaves the hold in place.
- R5: In latched style, the hold is released at the first edge that sees `ch_en_i[i]` = 1, provided an earlier edge during the hold saw it at 0. The edge that sees the enable at 0 does not release the hold.
- R6: In timed style (`cfg_retry_mode_i[i]` = 1) with interval N = `retry_cycles_i`, the line stays pulled down for exactly N+1 cycles after the entry edge when the fault is gone by then. If the fault is still present when the interval ends, the wait starts over with another N+1 cycles.
- R7: One cycle after a timed release lets `line_i` rise, `ch_softstart_o` equals `ch_en_i` for exactly one cycle. It is 0 at all other times.
- R8: While `cfg_pgood_mode_i` = 1, all holds are cleared and faults are not propagated. The line has no shutdown effect. `line_pd_o` is 1 exactly when some enabled channel has `pgood_i` = 0.
- R9: After reset, `line_pd_o` and `ch_softstart_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_fault_i | input | NUM_CH | Per-channel internal fault flag |
| ch_en_i | input | NUM_CH | Per-channel enable command |
| clear_all_i | input | 1 | Group clear/restore/reset command strobe |
| stat_w1c_i | input | NUM_CH | Per-channel status-bit write-one strobe |
| line_i | input | 1 | Resolved level of the shared line (low = fault) |
| cfg_prop_en_i | input | NUM_CH | Channel pulls the line on its own fault |
| cfg_resp_en_i | input | NUM_CH | Channel shuts down while the line is low |
| cfg_retry_mode_i | input | NUM_CH | 1 = timed group retry, 0 = latched |
| cfg_pgood_mode_i | input | 1 | Use the line as a power-good output |
| pgood_i | input | NUM_CH | Per-channel output-in-window flag |
| retry_cycles_i | input | RETRY_W | Retry interval N in cycles |
| line_pd_o | output | 1 | Pull-down enable for the shared line |
| ch_shutdown_o | output | NUM_CH | Per-channel shutdown |
| ch_softstart_o | output | NUM_CH | Per-channel soft-start request pulse |

## Verification
The bench targets the exact end of the retry window. A design off by one would release the line a cycle early or late. A design that ignores a fault still present at the end of the window would let go of the line while the fault is live. For the off-then-on release, the bench holds the enable low for a whole edge before raising it. A design that released on the low edge would free the line too soon. The bench pulses another channel's status strobe and checks that the hold remains, which catches strobes decoded to all channels. It confirms that soft-start comes as a single pulse one cycle after the line rises, and randomised line pulls check that shutdown follows the line with no delay.

// File: rtl/fault_line_pkg.sv
package fault_line_pkg;

    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,
        HS_LATCH = 2'd1,
        HS_RETRY = 2'd2
    } hold_state_e;

    typedef struct packed {
        logic prop_en;
        logic resp_en;
        logic retry_mode;
    } ch_cfg_t;

    // True when any enabled channel reports its output outside the window.
    function automatic logic pgood_fail(input logic [31:0] good, input logic [31:0] en);
        return |(en & ~good);
    endfunction

endpackage

// File: rtl/fl_hold_ch.sv
module fl_hold_ch
    import fault_line_pkg::*;
#(
    parameter int RETRY_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  ch_cfg_t            cfg_i,
    input  logic               inhibit_i,
    input  logic               fault_i,
    input  logic               en_i,
    input  logic               clr_i,
    input  logic [RETRY_W-1:0] retry_cycles_i,
    output logic               hold_o,
    output logic               retry_rel_o
);

    hold_state_e        state_q;
    logic [RETRY_W-1:0] cnt_q;
    logic               off_seen_q;
    logic               cnt_zero;

    assign cnt_zero    = (cnt_q == '0);
    assign hold_o      = (state_q != HS_IDLE);
    assign retry_rel_o = (state_q == HS_RETRY) && cnt_zero && !fault_i
                         && !clr_i && !inhibit_i;

    always_ff @(posedge clk) begin
        if (rst || inhibit_i) begin
            state_q    <= HS_IDLE;
            cnt_q      <= '0;
            off_seen_q <= 1'b0;
        end else begin
            unique case (state_q)
                HS_IDLE: begin
                    if (cfg_i.prop_en && fault_i) begin
                        state_q    <= cfg_i.retry_mode ? HS_RETRY : HS_LATCH;
                        cnt_q      <= retry_cycles_i;
                        off_seen_q <= 1'b0;
                    end
                end
                HS_LATCH: begin
                    if (clr_i || (en_i && off_seen_q)) begin
                        state_q    <= HS_IDLE;
                        off_seen_q <= 1'b0;
                    end else if (!en_i) begin
                        off_seen_q <= 1'b1;
                    end
                end
                HS_RETRY: begin
                    if (clr_i) begin
                        state_q <= HS_IDLE;
                    end else if (!cnt_zero) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else if (fault_i) begin
                        cnt_q <= retry_cycles_i;
                    end else begin
                        state_q <= HS_IDLE;
                    end
                end
                default: state_q <= HS_IDLE;
            endcase
        end
    end

    // R1
    prop_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == HS_IDLE && cfg_i.prop_en && fault_i && !inhibit_i) |=> hold_o);

    // R3
    latch_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == HS_LATCH && !clr_i && !inhibit_i && !(en_i && off_seen_q))
        |=> (state_q == HS_LATCH));

    // R4
    clear_release_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_o && clr_i) |=> !hold_o);

    // R6
    retry_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == HS_RETRY && !cnt_zero && !clr_i && !inhibit_i)
        |=> (state_q == HS_RETRY && cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/fl_restart_seq.sv
module fl_restart_seq #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_i,
    input  logic              retry_rel_i,
    input  logic [NUM_CH-1:0] en_i,
    output logic [NUM_CH-1:0] softstart_o
);

    logic              line_q;
    logic              pend_q;
    logic              rise;
    logic [NUM_CH-1:0] ss_q;

    assign rise        = line_i && !line_q;
    assign softstart_o = ss_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= 1'b1;
            pend_q <= 1'b0;
            ss_q   <= '0;
        end else begin
            line_q <= line_i;
            ss_q   <= (rise && pend_q) ? en_i : '0;
            if (retry_rel_i)
                pend_q <= 1'b1;
            else if (rise)
                pend_q <= 1'b0;
        end
    end

    // R7
    softstart_group_chk: assert property (@(posedge clk) disable iff (rst)
        (rise && pend_q) |=> (softstart_o == $past(en_i)));

    // R7
    softstart_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (softstart_o != '0) |=> (softstart_o == '0));

endmodule

// File: rtl/fl_line_drive.sv
module fl_line_drive
    import fault_line_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              pgood_mode_i,
    input  logic [NUM_CH-1:0] hold_i,
    input  logic [NUM_CH-1:0] pgood_i,
    input  logic [NUM_CH-1:0] en_i,
    input  logic [NUM_CH-1:0] resp_en_i,
    input  logic              line_i,
    output logic              line_pd_o,
    output logic [NUM_CH-1:0] shutdown_o
);

    logic [31:0] good_w;
    logic [31:0] en_w;

    always_comb begin
        good_w = '1;
        en_w   = '0;
        good_w[NUM_CH-1:0] = pgood_i;
        en_w[NUM_CH-1:0]   = en_i;
    end

    always_comb begin
        if (pgood_mode_i) begin
            line_pd_o  = pgood_fail(good_w, en_w);
            shutdown_o = ~en_i;
        end else begin
            line_pd_o  = |hold_i;
            shutdown_o = ~en_i | (resp_en_i & {NUM_CH{~line_i}});
        end
    end

endmodule

// File: rtl/fault_line_ctrl.sv
module fault_line_ctrl
    import fault_line_pkg::*;
#(
    parameter int NUM_CH  = 4,
    parameter int RETRY_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_CH-1:0]  ch_fault_i,
    input  logic [NUM_CH-1:0]  ch_en_i,
    input  logic               clear_all_i,
    input  logic [NUM_CH-1:0]  stat_w1c_i,
    input  logic               line_i,
    input  logic [NUM_CH-1:0]  cfg_prop_en_i,
    input  logic [NUM_CH-1:0]  cfg_resp_en_i,
    input  logic [NUM_CH-1:0]  cfg_retry_mode_i,
    input  logic               cfg_pgood_mode_i,
    input  logic [NUM_CH-1:0]  pgood_i,
    input  logic [RETRY_W-1:0] retry_cycles_i,
    output logic               line_pd_o,
    output logic [NUM_CH-1:0]  ch_shutdown_o,
    output logic [NUM_CH-1:0]  ch_softstart_o
);

    logic [NUM_CH-1:0] hold_w;
    logic [NUM_CH-1:0] rel_w;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        ch_cfg_t cfg_w;
        assign cfg_w.prop_en    = cfg_prop_en_i[g];
        assign cfg_w.resp_en    = cfg_resp_en_i[g];
        assign cfg_w.retry_mode = cfg_retry_mode_i[g];

        fl_hold_ch #(.RETRY_W(RETRY_W)) hold_i (
            .clk            (clk),
            .rst            (rst),
            .cfg_i          (cfg_w),
            .inhibit_i      (cfg_pgood_mode_i),
            .fault_i        (ch_fault_i[g]),
            .en_i           (ch_en_i[g]),
            .clr_i          (clear_all_i | stat_w1c_i[g]),
            .retry_cycles_i (retry_cycles_i),
            .hold_o         (hold_w[g]),
            .retry_rel_o    (rel_w[g])
        );
    end

    fl_restart_seq #(.NUM_CH(NUM_CH)) restart_i (
        .clk         (clk),
        .rst         (rst),
        .line_i      (line_i),
        .retry_rel_i (|rel_w),
        .en_i        (ch_en_i),
        .softstart_o (ch_softstart_o)
    );

    fl_line_drive #(.NUM_CH(NUM_CH)) drive_i (
        .pgood_mode_i (cfg_pgood_mode_i),
        .hold_i       (hold_w),
        .pgood_i      (pgood_i),
        .en_i         (ch_en_i),
        .resp_en_i    (cfg_resp_en_i),
        .line_i       (line_i),
        .line_pd_o    (line_pd_o),
        .shutdown_o   (ch_shutdown_o)
    );

    // R8
    pgood_no_hold_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_pgood_mode_i |=> (hold_w == '0 || !$past(cfg_pgood_mode_i)));

endmodule

// File: tb/fault_line_ctrl_tb_top.sv
module fault_line_ctrl_tb_top;
    localparam int NC = 4;
    localparam int RW = 16;
    localparam int N  = 5;

    logic          clk = 1'b0;
    logic          rst;
    logic [NC-1:0] fault, en, w1c, prop, resp, rmode, pg;
    logic          clr, pgmode, ext_pull;
    logic [RW-1:0] rcyc;
    logic          line, line_pd;
    logic [NC-1:0] sd, ss;
    int            nchk = 0;
    int            nfail = 0;

    always #2 clk = ~clk;
    assign line = ~(line_pd | ext_pull);

    fault_line_ctrl #(.NUM_CH(NC), .RETRY_W(RW)) dut_i (
        .clk(clk), .rst(rst), .ch_fault_i(fault), .ch_en_i(en),
        .clear_all_i(clr), .stat_w1c_i(w1c), .line_i(line),
        .cfg_prop_en_i(prop), .cfg_resp_en_i(resp), .cfg_retry_mode_i(rmode),
        .cfg_pgood_mode_i(pgmode), .pgood_i(pg), .retry_cycles_i(rcyc),
        .line_pd_o(line_pd), .ch_shutdown_o(sd), .ch_softstart_o(ss)
    );

    function automatic logic [NC-1:0] exp_sd(logic [NC-1:0] e, logic [NC-1:0] r, logic l);
        return ~e | (r & {NC{~l}});
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        void'($urandom(32'd7741));
        rst = 1; fault = '0; en = '1; w1c = '0; prop = '0; resp = '1; rmode = '0;
        pg = '1; clr = 0; pgmode = 0; ext_pull = 0; rcyc = RW'(N);
        tick(3);
        rst = 0;
        tick(1);
        // R9 reset state
        check("R9 line_pd", 32'(line_pd), 0);
        check("R9 softstart", 32'(ss), 0);

        // R1 propagation with latched style on ch0
        prop = 4'b0101; rmode = 4'b0100;
        fault[0] = 1; tick(1); fault[0] = 0;
        check("R1 line_pd after fault", 32'(line_pd), 1);
        #1 check("R2 all shut down", 32'(sd), 32'(4'hF));
        tick(10);
        check("R3 latched hold", 32'(line_pd), 1);
        w1c[1] = 1; tick(1); w1c[1] = 0; tick(1);
        check("R4 other w1c ignored", 32'(line_pd), 1);
        w1c[0] = 1; tick(1); w1c[0] = 0;
        check("R4 own w1c release", 32'(line_pd), 0);
        fault[0] = 1; tick(1); fault[0] = 0;
        check("R1 relatch", 32'(line_pd), 1);
        clr = 1; tick(1); clr = 0;
        check("R4 clear_all release", 32'(line_pd), 0);

        // R5 off-then-on release
        fault[0] = 1; tick(1); fault[0] = 0;
        en[0] = 0; tick(1);
        check("R5 held on off edge", 32'(line_pd), 1);
        en[0] = 1; tick(1);
        check("R5 released on on edge", 32'(line_pd), 0);
        check("R7 no softstart after latch", 32'(ss), 0);

        // R1 no propagation when disabled
        fault[1] = 1; tick(2); fault[1] = 0;
        check("R1 prop disabled", 32'(line_pd), 0);

        // R6 timed retry on ch2
        fault[2] = 1; tick(1); fault[2] = 0;
        check("R6 entry", 32'(line_pd), 1);
        tick(N);
        check("R6 held N cycles", 32'(line_pd), 1);
        tick(1);
        check("R6 released at N+1", 32'(line_pd), 0);
        check("R7 none before rise seen", 32'(ss), 0);
        tick(1);
        check("R7 softstart group", 32'(ss), 32'(en));
        tick(1);
        check("R7 single pulse", 32'(ss), 0);

        // R6 fault persisting reloads the wait
        fault[2] = 1; tick(1);
        tick(N + 1);
        check("R6 reload while fault present", 32'(line_pd), 1);
        fault[2] = 0;
        tick(N);
        check("R6 held during reload", 32'(line_pd), 1);
        tick(1);
        check("R6 released after reload", 32'(line_pd), 0);
        tick(1);
        check("R7 softstart after reload", 32'(ss), 32'(en));

        // R8 power-good mode
        tick(2);
        pgmode = 1; fault[0] = 1; tick(2);
        check("R8 no fault propagation", 32'(line_pd), 0);
        pg[3] = 0; #1;
        check("R8 pgood low pulls line", 32'(line_pd), 1);
        check("R8 no line shutdown", 32'(sd), 0);
        en[3] = 0; #1;
        check("R8 disabled channel ignored", 32'(line_pd), 0);
        pg = '1; en = '1; fault = '0; tick(1);
        pgmode = 0; tick(1);
        check("R8 holds cleared", 32'(line_pd), 0);

        // R2 random external pulls, random enables and responses
        prop = '0;
        for (int i = 0; i < 3000; i++) begin
            ext_pull = 1'($urandom);
            en       = NC'($urandom);
            resp     = NC'($urandom);
            #1;
            check("R2 shutdown follows line", 32'(sd), 32'(exp_sd(en, resp, line)));
            tick(1);
        end

        // R1 random propagation bursts
        ext_pull = 0; en = '1; resp = '1; rmode = '0;
        for (int i = 0; i < 200; i++) begin
            prop  = NC'($urandom);
            fault = NC'($urandom);
            tick(1);
            check("R1 random propagation", 32'(line_pd), 32'(|(prop & fault)));
            fault = '0; clr = 1; tick(1); clr = 0;
            check("R4 random clear", 32'(line_pd), 0);
        end

        finish_up();
    end
endmodule